// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns an effective address into a real address by walking a radix tree of 64-bit entries held in memory. A walk begins from a single root descriptor word that carries the total number of translated address bits, the base of the top directory and the index width of that directory. The walker then reads one entry per level over a simple read port: one request, one response, never more than one read in flight.

Each level is first checked against a fixed set of legal index widths. A legal level turns a slice of the effective address into an entry address, and the entry that comes back is either a pointer to the next directory, a leaf, or invalid. At a leaf the walker combines the page number from the entry with the untranslated low bits of the effective address and reports the real address, the page size as a bit count, and the leaf entry itself. A walk that breaks a size rule or reaches an invalid entry ends with a fault code in place of a translation.

Top module: `radix_walker`

## Requirements
- R1: A walk is started by `start` while idle. The root word is decoded as: total size = {root_word[62:61], root_word[7:5]} read as a 5-bit number plus 31; directory base = root_word with every bit outside 59:8 cleared; index width = root_word[4:0].
- R2: At each legal level exactly one read is issued: `mem_req` is high for one cycle with `mem_addr` = base + 8 × ((ea >> (size − width)) masked to `width` bits). No further request is made until `mem_rsp_valid` returns that read.
- R3: A directory base whose bits below 2^(width+3) are set is used with those bits cleared; this never causes a fault.
- R4: Before reading, the level is checked: level 0 needs size 52 and width 13, levels 1 and 2 need width 9, level 3 accepts width 9 or 5, and any deeper level is illegal. An illegal level ends the walk with `fault` = 2'b10 and no read for that level.
- R5: A returned entry with bit 63 clear ends the walk with `fault` = 2'b01.
- R6: For a valid entry the remaining size drops by the current width; if bit 62 is clear the walk continues at the next level with base = entry bits 59:8 (others cleared) and width = entry bits 4:0.
- R7: For a valid entry with bit 62 set the walk ends with `fault` = 2'b00, `page_bits` = remaining size, `leaf_entry` = the entry, and `real_addr` = (entry bits 56:12, others cleared, with the low `page_bits` bits cleared) OR (ea low `page_bits` bits).
- R8: The end of every walk is marked by `done` high for exactly one cycle as `busy` drops; results hold until the next walk ends. A `start` while `busy` is ignored.
- R9: After reset the walker is idle: `busy`, `mem_req` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (idle only) |
| ea | input | 64 | Effective address to translate |
| root_word | input | 64 | Root descriptor: size, base, index width |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Read request, one cycle |
| mem_addr | output | 64 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| done | output | 1 | Walk finished, one cycle |
| fault | output | 2 | {bad configuration, invalid entry} |
| leaf_entry | output | 64 | Last entry read |
| page_bits | output | 7 | Page size as a number of offset bits |
| real_addr | output | 64 | Translated address |

## Verification
The bench builds the walker with its default parameters: four levels, a 52-bit root size with a 13-bit root index, 9-bit middle indexes and a 5-bit alternative at the last level. With these values all four page sizes (30, 21, 12 and 16 offset bits) are reachable, as is a walk that runs past the fourth level. Random trees with misaligned bases, invalid entries at any depth, illegal index widths and bad root sizes are walked under random response latency, and each outcome, including the full list of requested addresses, is compared with a model in the bench.

// File: rtl/radix_walker.sv
module radix_walker #(
  parameter int LEVELS    = 4,
  parameter int ROOT_SIZE = 52,
  parameter int ROOT_NLS  = 13,
  parameter int MID_NLS   = 9,
  parameter int ALT_NLS   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] ea,
  input  logic [63:0] root_word,
  output logic        busy,
  output logic        mem_req,
  output logic [63:0] mem_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        done,
  output logic [1:0]  fault,
  output logic [63:0] leaf_entry,
  output logic [6:0]  page_bits,
  output logic [63:0] real_addr
);

  localparam int LW = $clog2(LEVELS + 1);
  localparam logic [63:0] BASE_MASK = 64'h0FFF_FFFF_FFFF_FF00;
  localparam logic [63:0] RPN_MASK  = 64'h01FF_FFFF_FFFF_F000;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_WAIT} st_t;

  st_t         st;
  logic [LW-1:0] lvl;
  logic [6:0]  size_q;
  logic [4:0]  nls_q;
  logic [63:0] base_q, ea_q;
  logic        legal;
  logic [6:0]  rem_size;
  logic [5:0]  align_bits;
  logic [63:0] idx, amask, pmask;
  logic        unused_root;

  assign unused_root = ^{root_word[63], root_word[60]};

  always_comb begin
    if (int'(lvl) == 0)
      legal = (int'(size_q) == ROOT_SIZE) && (int'(nls_q) == ROOT_NLS);
    else if (int'(lvl) < LEVELS - 1)
      legal = (int'(nls_q) == MID_NLS);
    else if (int'(lvl) == LEVELS - 1)
      legal = (int'(nls_q) == MID_NLS) || (int'(nls_q) == ALT_NLS);
    else
      legal = 1'b0;
  end

  assign rem_size   = size_q - {2'b00, nls_q};
  assign align_bits = {1'b0, nls_q} + 6'd3;
  assign idx        = (ea_q >> rem_size) & ((64'd1 << nls_q) - 64'd1);
  assign amask      = (64'd1 << align_bits) - 64'd1;
  assign pmask      = (64'd1 << rem_size) - 64'd1;

  assign busy     = (st != S_IDLE);
  assign mem_req  = (st == S_LOOK) && legal;
  assign mem_addr = (base_q & ~amask) + (idx << 3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      lvl        <= '0;
      size_q     <= '0;
      nls_q      <= '0;
      base_q     <= '0;
      ea_q       <= '0;
      done       <= 1'b0;
      fault      <= 2'b00;
      leaf_entry <= '0;
      page_bits  <= '0;
      real_addr  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st     <= S_LOOK;
          lvl    <= '0;
          ea_q   <= ea;
          size_q <= {2'b00, root_word[62:61], root_word[7:5]} + 7'd31;
          base_q <= root_word & BASE_MASK;
          nls_q  <= root_word[4:0];
        end
        S_LOOK: begin
          if (legal) st <= S_WAIT;
          else begin
            st    <= S_IDLE;
            done  <= 1'b1;
            fault <= 2'b10;
          end
        end
        S_WAIT: if (mem_rsp_valid) begin
          leaf_entry <= mem_rsp_data;
          if (!mem_rsp_data[63]) begin
            st    <= S_IDLE;
            done  <= 1'b1;
            fault <= 2'b01;
          end else if (mem_rsp_data[62]) begin
            st        <= S_IDLE;
            done      <= 1'b1;
            fault     <= 2'b00;
            page_bits <= rem_size;
            real_addr <= (mem_rsp_data & RPN_MASK & ~pmask) | (ea_q & pmask);
          end else begin
            st     <= S_LOOK;
            lvl    <= lvl + 1'b1;
            size_q <= rem_size;
            base_q <= mem_rsp_data & BASE_MASK;
            nls_q  <= mem_rsp_data[4:0];
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_one_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_addr_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[2:0] == 3'b000));

  assert_fault_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot0(fault));

  assert_bad_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOOK && !legal) |=> (done && fault == 2'b10));

  assert_leaf_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && mem_rsp_valid && mem_rsp_data[63] && mem_rsp_data[62])
      |=> (done && fault == 2'b00 && page_bits == $past(rem_size)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_end_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

endmodule

// File: tb/radix_walker_bench.sv
module radix_walker_bench;
  localparam logic [63:0] BMASK = 64'h0FFF_FFFF_FFFF_FF00;
  localparam logic [63:0] RMASK = 64'h01FF_FFFF_FFFF_F000;

  logic clk = 0, rst_n = 0, start = 0;
  logic [63:0] ea = 0, root_word = 0;
  logic busy, mem_req, done;
  logic [63:0] mem_addr, leaf_entry, real_addr;
  logic mem_rsp_valid = 0;
  logic [63:0] mem_rsp_data = 0;
  logic [1:0] fault;
  logic [6:0] page_bits;

  int nchk = 0, nbad = 0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] got_q[$], exp_q[$];

  always #2 clk = ~clk;

  radix_walker u_radix_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .root_word(root_word),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .leaf_entry(leaf_entry),
    .page_bits(page_bits), .real_addr(real_addr));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (mem_req) begin
        logic [63:0] a;
        a = mem_addr;
        got_q.push_back(a);
        repeat (1 + $urandom_range(0, 2)) @(negedge clk);
        mem_rsp_valid = 1;
        mem_rsp_data = mem.exists(a) ? mem[a] : 64'd0;
      end
    end
  end

  function automatic logic [63:0] ent_addr(logic [63:0] b, int n, int sz, logic [63:0] e);
    logic [63:0] ix, am;
    ix = (e >> (sz - n)) & ((64'd1 << n) - 1);
    am = (64'd1 << (n + 3)) - 1;
    return (b & ~am) + (ix << 3);
  endfunction

  function automatic bit lvl_ok(int l, int sz, int n);
    case (l)
      0: return sz == 52 && n == 13;
      1, 2: return n == 9;
      3: return n == 9 || n == 5;
      default: return 0;
    endcase
  endfunction

  task automatic ref_walk(input logic [63:0] e, input logic [63:0] w, output logic [1:0] f,
                          output logic [63:0] ra, output int pg, output logic [63:0] en);
    int sz, n;
    logic [63:0] b, a, d, pm;
    sz = int'({w[62:61], w[7:5]}) + 31;
    b = w & BMASK;
    n = int'(w[4:0]);
    exp_q.delete();
    f = 2'b10; ra = 0; pg = 0; en = 0;
    for (int l = 0; l < 8; l++) begin
      if (!lvl_ok(l, sz, n)) begin f = 2'b10; return; end
      a = ent_addr(b, n, sz, e);
      exp_q.push_back(a);
      d = mem.exists(a) ? mem[a] : 64'd0;
      if (!d[63]) begin f = 2'b01; return; end
      sz -= n;
      if (d[62]) begin
        pm = (64'd1 << sz) - 1;
        ra = (d & RMASK & ~pm) | (e & pm);
        pg = sz; en = d; f = 2'b00;
        return;
      end
      b = d & BMASK;
      n = int'(d[4:0]);
    end
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  // kind: 0 normal, 1 invalid entry, 2 bad width, 3 past last level, 4 bad root size, 5 misaligned bases
  task automatic build(input logic [63:0] e, input int kind, output logic [63:0] w);
    int leafl, badl, sz, n, nn;
    bit alt, stop;
    logic [63:0] b, nb, a, d;
    mem.delete();
    leafl = (kind == 3) ? 9 : $urandom_range(1, 3);
    alt = $urandom_range(0, 1);
    badl = (kind == 2) ? $urandom_range(0, leafl - 1) : $urandom_range(0, leafl);
    b = r64() & BMASK & ~64'hFFFF;
    if (kind == 5) b |= 64'(($urandom & 8'hFF)) << 8;
    w = b | (64'd5 << 5) | 64'd13 | (64'($urandom_range(0, 1)) << 63);
    w |= (kind == 4) ? (64'd1 << 61) : (64'd2 << 61);
    sz = 52; n = 13;
    for (int l = 0; l < 4; l++) begin
      a = ent_addr(b, n, sz, e);
      stop = 0;
      if (l == leafl) begin
        d = 64'hC000_0000_0000_0000 | (r64() & RMASK) | 64'($urandom & 12'hFFF);
        stop = 1;
      end else begin
        nn = (l + 1 == 3 && alt) ? 5 : 9;
        if (kind == 2 && l == badl) begin nn = 7; stop = 1; end
        nb = r64() & BMASK & ~((64'd1 << (nn + 3)) - 1);
        if (kind == 5) nb |= 64'(($urandom & 8'hFF)) << 8;
        d = 64'h8000_0000_0000_0000 | nb | 64'(($urandom & 8'hE0)) | 64'(nn)
            | (64'($urandom_range(0, 3)) << 60);
      end
      if (kind == 1 && l == badl) begin d[63] = 0; stop = 1; end
      mem[a] = d;
      if (stop) break;
      sz -= n; n = nn; b = nb;
    end
  endtask

  task automatic run_walk(input logic [63:0] e, input logic [63:0] w, input string tag, input bit poke);
    logic [1:0] ef; logic [63:0] era, een; int epg, t;
    ref_walk(e, w, ef, era, epg, een);
    got_q.delete();
    @(negedge clk);
    ea = e; root_word = w; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      @(negedge clk);
      ea = ~e; root_word = r64(); start = 1;
      @(negedge clk);
      start = 0;
    end
    t = 0;
    while (!done && t < 300) begin @(negedge clk); t++; end
    if (!done) begin
      check(0, {tag, " R8 watchdog"}, 0, 1);
      return;
    end
    check(fault == ef, {tag, " R4/R5 fault"}, 64'(fault), 64'(ef));
    check(got_q.size() == exp_q.size(), {tag, " R2 read count"}, 64'(got_q.size()), 64'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], {tag, " R1/R2/R3 entry address"}, got_q[i], exp_q[i]);
    if (ef == 2'b00) begin
      check(real_addr == era, {tag, " R7 real address"}, real_addr, era);
      check(int'(page_bits) == epg, {tag, " R6/R7 page bits"}, 64'(page_bits), 64'(epg));
      check(leaf_entry == een, {tag, " R7 leaf entry"}, leaf_entry, een);
    end
    @(negedge clk);
    check(!done && !busy, {tag, " R8 done pulse"}, 64'({done, busy}), 0);
  endtask

  initial begin
    logic [63:0] w, e;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!busy && !mem_req && !done, "R9 reset idle", 64'({busy, mem_req, done}), 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !mem_req && !done, "R9 after reset", 64'({busy, mem_req, done}), 0);

    e = 64'hFFFF_FFFF_FFFF_FFFF; build(e, 0, w); run_walk(e, w, "dir all-ones ea", 0);
    e = 64'd0;                   build(e, 0, w); run_walk(e, w, "dir zero ea", 0);
    e = r64();                   build(e, 5, w); run_walk(e, w, "dir R3 misaligned", 0);
    e = r64();                   build(e, 4, w); run_walk(e, w, "dir R1 root size", 0);
    e = r64();                   build(e, 3, w); run_walk(e, w, "dir R4 past last level", 0);
    e = r64();                   build(e, 0, w); run_walk(e, w, "dir R8 start while busy", 1);

    for (int i = 0; i < 400; i++) begin
      e = r64();
      build(e, $urandom_range(0, 5), w);
      run_walk(e, w, "rand", i % 17 == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    nchk++; nbad++;
    $display("FAIL R8 global watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule